// File: doc/BRIEF.md
# Receive Interrupt Mode Controller

This block sits between a serial receiver and a host. It takes the receiver's character-valid strobe and its special-condition flags, and drives the host's receive interrupt line and a per-character DMA request. A two-bit field in a write-only control byte selects how received characters are reported. They can be ignored, interrupt on every character, interrupt on special conditions only, or interrupt on the first character of a frame and then move later characters by DMA.

In first-character mode the host takes the first interrupt and starts its DMA channel. The block then raises one DMA request per character. An end-of-message, overrun or parity condition raises a special-condition interrupt, stops the requests and latches. Characters are then ignored until the host sends an error-reset command. That command re-arms detection of a new first character. A pending interrupt holds until the host acknowledges it. A two-bit vector tells a character interrupt apart from a special-condition interrupt.

Top module: `rx_irq_mode_ctrl`

## Requirements
- R1: A write strobe captures the mode from bits 4:3 of the control byte. 00 means receive interrupts off, 01 means first character then DMA, 10 means every character, and 11 means special conditions only.
- R2: In mode 01, the first accepted character after arming sets the interrupt with vector 01 in the cycle after the strobe. It raises no DMA request.
- R3: In mode 01, each later accepted character gives a one-cycle DMA request in the cycle after its strobe. It raises no new character interrupt.
- R4: Special-condition flag bits are [0] end-of-message, [1] overrun and [2] parity error. Any of them sets the interrupt with vector 10 in the next cycle in modes 01, 10 and 11. In mode 00 they are ignored.
- R5: A special condition latches a hold. While the hold is set, characters produce no DMA request and no interrupt. The error-reset command clears the hold and re-arms first-character detection. A character that arrives in the same cycle as error-reset is ignored.
- R6: A pending interrupt stays asserted until the interrupt-acknowledge command, and it reads zero in the cycle after that command. The vector reads 00 when nothing is pending. It reads 10 when a special condition is pending, whether or not a character interrupt is also pending.
- R7: If a character and a special condition arrive in the same cycle, the special condition wins. The character gives neither a DMA request nor a character interrupt.
- R8: In mode 10 every accepted character sets the interrupt with vector 01. In mode 11 characters never interrupt. In mode 00 nothing interrupts.
- R9: A mode write made while a frame is streaming or a hold is set is deferred. It takes effect at the first clock edge at which the block is idle, meaning no hold and not streaming.
- R10: After reset the interrupt, vector and DMA request are zero, and the mode is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | CTL_W | Control byte; mode field at bits 4:3 |
| char_valid | input | 1 | Received character ready strobe |
| spec_flags | input | N_SPEC | Special-condition flags (eom, overrun, parity) |
| err_reset | input | 1 | Host error-reset command strobe |
| int_ack | input | 1 | Host interrupt-acknowledge command strobe |
| irq | output | 1 | Receive interrupt request |
| irq_vec | output | 2 | 00 none, 01 character, 10 special condition |
| dma_req | output | 1 | One-cycle DMA request per streamed character |

## Verification
Every result is registered, so the interrupt, vector and DMA request are due exactly one clock edge after the strobe that caused them. A deferred mode write takes effect on the first edge at which the block is idle, which is one edge after the error-reset that clears the hold. The bench drives each stimulus just after a rising edge and compares all three outputs one time unit after the following edge. A bench model steps through the same edge and provides the expected values. Directed sequences cover first-character handoff, deferral, collisions and the hold, and a seeded random run exercises the mixed cases.

// File: rtl/rxim_pkg.sv
package rxim_pkg;
   typedef enum logic [1:0] {
      RXM_OFF     = 2'b00,
      RXM_FIRST   = 2'b01,
      RXM_EVERY   = 2'b10,
      RXM_SPECIAL = 2'b11
   } rxm_mode_e;

   localparam logic [1:0] VEC_NONE = 2'b00;
   localparam logic [1:0] VEC_CHAR = 2'b01;
   localparam logic [1:0] VEC_SPEC = 2'b10;
endpackage

// File: rtl/rxim_mode_sel.sv
module rxim_mode_sel
   import rxim_pkg::*;
#(
   parameter int CTL_W    = 8,
   parameter int MODE_LSB = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_data,
   input  logic             idle,
   output rxm_mode_e        act_mode
);
   generate
      if (MODE_LSB + 2 > CTL_W) begin : g_bad_field
         $error("rxim_mode_sel: mode field outside control byte");
      end
   endgenerate

   rxm_mode_e field;
   rxm_mode_e pend_mode;
   logic      unused_ctl;

   assign field      = rxm_mode_e'(ctl_data[MODE_LSB +: 2]);
   assign unused_ctl = ^ctl_data;

   // R9: a write lands in the pending copy; it moves to the active copy only while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_mode <= RXM_OFF;
         act_mode  <= RXM_OFF;
      end else begin
         if (ctl_wr) pend_mode <= field;
         if (idle)   act_mode  <= ctl_wr ? field : pend_mode;
      end
   end
endmodule

// File: rtl/rxim_cond_mask.sv
module rxim_cond_mask #(
   parameter int              N_SPEC    = 3,
   parameter logic [N_SPEC-1:0] SPEC_MASK = '1
) (
   input  logic [N_SPEC-1:0] flags,
   output logic              hit
);
   generate
      if (N_SPEC < 1) begin : g_bad_count
         $error("rxim_cond_mask: need at least one condition flag");
      end
   endgenerate

   logic [N_SPEC-1:0] kept;

   for (genvar i = 0; i < N_SPEC; i++) begin : g_flag
      if (SPEC_MASK[i]) begin : g_on
         assign kept[i] = flags[i];
      end else begin : g_off
         assign kept[i] = 1'b0;
      end
   end

   assign hit = |kept;
endmodule

// File: rtl/rxim_rx_seq.sv
module rxim_rx_seq
   import rxim_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  rxm_mode_e act_mode,
   input  logic      char_valid,
   input  logic      spec_hit,
   input  logic      err_reset,
   output logic      char_evt,
   output logic      spec_evt,
   output logic      dma_req,
   output logic      idle
);
   logic held;
   logic streaming;
   logic char_ok;

   assign spec_evt = spec_hit && (act_mode != RXM_OFF);
   // R7: a colliding special condition swallows the character; R5: hold blocks it
   assign char_ok  = char_valid && !held && !err_reset && !spec_evt;
   assign char_evt = char_ok && ((act_mode == RXM_EVERY) ||
                                 (act_mode == RXM_FIRST && !streaming));
   assign idle     = !held && !streaming;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held      <= 1'b0;
         streaming <= 1'b0;
         dma_req   <= 1'b0;
      end else begin
         dma_req <= char_ok && (act_mode == RXM_FIRST) && streaming;
         if (spec_evt)       held <= 1'b1;
         else if (err_reset) held <= 1'b0;
         if (spec_evt || err_reset)                 streaming <= 1'b0;
         else if (char_ok && act_mode == RXM_FIRST) streaming <= 1'b1;
      end
   end
endmodule

// File: rtl/rxim_irq_hold.sv
module rxim_irq_hold
   import rxim_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       char_evt,
   input  logic       spec_evt,
   input  logic       int_ack,
   output logic       irq,
   output logic [1:0] irq_vec
);
   logic pend_char;
   logic pend_spec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_char <= 1'b0;
         pend_spec <= 1'b0;
      end else begin
         if (char_evt)     pend_char <= 1'b1;
         else if (int_ack) pend_char <= 1'b0;
         if (spec_evt)     pend_spec <= 1'b1;
         else if (int_ack) pend_spec <= 1'b0;
      end
   end

   assign irq     = pend_char || pend_spec;
   assign irq_vec = pend_spec ? VEC_SPEC : (pend_char ? VEC_CHAR : VEC_NONE);
endmodule

// File: rtl/rx_irq_mode_ctrl.sv
module rx_irq_mode_ctrl
   import rxim_pkg::*;
#(
   parameter int                CTL_W     = 8,
   parameter int                MODE_LSB  = 3,
   parameter int                N_SPEC    = 3,
   parameter logic [N_SPEC-1:0] SPEC_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_data,
   input  logic              char_valid,
   input  logic [N_SPEC-1:0] spec_flags,
   input  logic              err_reset,
   input  logic              int_ack,
   output logic              irq,
   output logic [1:0]        irq_vec,
   output logic              dma_req
);
   rxm_mode_e act_mode;
   logic      spec_hit;
   logic      char_evt;
   logic      spec_evt;
   logic      idle;

   rxim_mode_sel #(.CTL_W(CTL_W), .MODE_LSB(MODE_LSB)) u_mode (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
      .idle(idle), .act_mode(act_mode)
   );

   rxim_cond_mask #(.N_SPEC(N_SPEC), .SPEC_MASK(SPEC_MASK)) u_mask (
      .flags(spec_flags), .hit(spec_hit)
   );

   rxim_rx_seq u_seq (
      .clk(clk), .rst_n(rst_n), .act_mode(act_mode), .char_valid(char_valid),
      .spec_hit(spec_hit), .err_reset(err_reset), .char_evt(char_evt),
      .spec_evt(spec_evt), .dma_req(dma_req), .idle(idle)
   );

   rxim_irq_hold u_irq (
      .clk(clk), .rst_n(rst_n), .char_evt(char_evt), .spec_evt(spec_evt),
      .int_ack(int_ack), .irq(irq), .irq_vec(irq_vec)
   );
endmodule

// File: rtl/rxim_checker.sv
module rxim_checker
   import rxim_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       char_valid,
   input logic       spec_hit,
   input logic       int_ack,
   input rxm_mode_e  act_mode,
   input logic       irq,
   input logic [1:0] irq_vec,
   input logic       dma_req
);
   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !int_ack |=> irq);

   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack && !spec_hit && !char_valid |=> !irq);

   p_vec_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> irq_vec == VEC_NONE);

   p_dma_from_char_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> $past(char_valid) && $past(act_mode) == RXM_FIRST);

   p_spec_blocks_dma_r7: assert property (@(posedge clk) disable iff (!rst_n)
      spec_hit |=> !dma_req);

   p_spec_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spec_hit && act_mode != RXM_OFF |=> irq && irq_vec == VEC_SPEC);

   p_off_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(act_mode) != RXM_OFF);
endmodule

bind rx_irq_mode_ctrl rxim_checker u_chk (
   .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .spec_hit(spec_hit),
   .int_ack(int_ack), .act_mode(act_mode), .irq(irq), .irq_vec(irq_vec),
   .dma_req(dma_req)
);

// File: tb/rx_irq_mode_ctrl_test.sv
module rx_irq_mode_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int CTL_W      = 8;
   localparam int MODE_LSB   = 3;
   localparam int N_SPEC     = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ctl_wr = 1'b0;
   logic [CTL_W-1:0]  ctl_data = '0;
   logic              char_valid = 1'b0;
   logic [N_SPEC-1:0] spec_flags = '0;
   logic              err_reset = 1'b0;
   logic              int_ack = 1'b0;
   logic              irq;
   logic [1:0]        irq_vec;
   logic              dma_req;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // bench model state
   logic [1:0] m_act, m_pend;
   logic       m_held, m_strm, m_pc, m_ps, m_dma;

   rx_irq_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
      .char_valid(char_valid), .spec_flags(spec_flags), .err_reset(err_reset),
      .int_ack(int_ack), .irq(irq), .irq_vec(irq_vec), .dma_req(dma_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [3:0] exp_out();
      logic [1:0] v;
      v = m_ps ? 2'b10 : (m_pc ? 2'b01 : 2'b00);
      return {m_pc | m_ps, v, m_dma};
   endfunction

   function automatic string pick_tag();
      logic [3:0] e;
      e = exp_out();
      if (e[0])             return "R3";
      if (e[2:1] == 2'b10)  return "R4";
      if (e[2:1] == 2'b01)  return "R2";
      return "R6";
   endfunction

   task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {irq,vec,dma} actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(string tag, bit wr, logic [CTL_W-1:0] data, bit cv,
                       logic [N_SPEC-1:0] fl, bit er, bit ack);
      logic       idle_now, spec, ok, cevt;
      logic [1:0] fld;
      logic [1:0] n_act, n_pend;
      logic       n_held, n_strm, n_pc, n_ps, n_dma;
      ctl_wr = wr; ctl_data = data; char_valid = cv; spec_flags = fl;
      err_reset = er; int_ack = ack;
      fld      = data[MODE_LSB +: 2];
      idle_now = !m_held && !m_strm;
      spec     = (|fl) && (m_act != 2'b00);
      ok       = cv && !m_held && !er && !spec;
      cevt     = ok && (m_act == 2'b10 || (m_act == 2'b01 && !m_strm));
      n_dma    = ok && m_act == 2'b01 && m_strm;
      n_pc     = cevt ? 1'b1 : (ack ? 1'b0 : m_pc);
      n_ps     = spec ? 1'b1 : (ack ? 1'b0 : m_ps);
      n_held   = spec ? 1'b1 : (er ? 1'b0 : m_held);
      n_strm   = (spec || er) ? 1'b0 : ((ok && m_act == 2'b01) ? 1'b1 : m_strm);
      n_pend   = wr ? fld : m_pend;
      n_act    = idle_now ? (wr ? fld : m_pend) : m_act;
      @(posedge clk);
      m_act = n_act; m_pend = n_pend; m_held = n_held; m_strm = n_strm;
      m_pc = n_pc; m_ps = n_ps; m_dma = n_dma;
      #1;
      check(tag == "" ? pick_tag() : tag, {irq, irq_vec, dma_req}, exp_out());
   endtask

   task automatic idle_step(string tag);
      step(tag, 0, '0, 0, '0, 0, 0);
   endtask

   function automatic logic [CTL_W-1:0] mode_byte(logic [1:0] m);
      logic [CTL_W-1:0] b;
      b = 8'hA5 & ~(8'h3 << MODE_LSB);
      b[MODE_LSB +: 2] = m;
      return b;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_act = 0; m_pend = 0; m_held = 0; m_strm = 0; m_pc = 0; m_ps = 0; m_dma = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R10", {irq, irq_vec, dma_req}, 4'b0000);
      rst_n = 1'b1;
      idle_step("R10");

      // mode 00: characters and conditions are silent
      step("R8", 0, '0, 1, 3'b000, 0, 0);
      step("R4", 0, '0, 0, 3'b010, 0, 0);
      idle_step("R8");

      // mode 01 through the control byte field
      step("R1", 1, mode_byte(2'b01), 0, '0, 0, 0);
      step("R2", 0, '0, 1, '0, 0, 0);
      step("R6", 0, '0, 0, '0, 0, 0);
      step("R6", 0, '0, 0, '0, 0, 1);
      step("R3", 0, '0, 1, '0, 0, 0);
      step("R3", 0, '0, 0, '0, 0, 0);
      step("R3", 0, '0, 1, '0, 0, 0);
      // deferred mode write while streaming
      step("R9", 1, mode_byte(2'b10), 1, '0, 0, 0);
      step("R9", 0, '0, 1, '0, 0, 0);
      // collision: condition wins
      step("R7", 0, '0, 1, 3'b100, 0, 0);
      step("R5", 0, '0, 1, '0, 0, 0);
      step("R6", 0, '0, 0, '0, 0, 1);
      step("R5", 0, '0, 1, '0, 0, 0);
      step("R5", 0, '0, 1, '0, 1, 0);
      step("R9", 0, '0, 0, '0, 0, 0);
      // mode 10 now active: every character interrupts
      step("R8", 0, '0, 1, '0, 0, 0);
      step("R8", 0, '0, 1, '0, 0, 1);
      step("R6", 0, '0, 0, '0, 0, 1);
      // mode 11: characters quiet, end-of-message interrupts
      step("R1", 1, mode_byte(2'b11), 0, '0, 0, 0);
      step("R8", 0, '0, 1, '0, 0, 0);
      step("R4", 0, '0, 0, 3'b001, 0, 0);
      step("R6", 0, '0, 0, '0, 0, 1);
      step("R5", 0, '0, 0, '0, 1, 0);

      // seeded random phase
      for (int i = 0; i < 600; i++) begin
         bit wr, cv, er, ack;
         logic [N_SPEC-1:0] fl;
         wr  = ($urandom % 100) < 4;
         cv  = ($urandom % 100) < 45;
         er  = ($urandom % 100) < 6;
         ack = ($urandom % 100) < 20;
         fl  = '0;
         for (int k = 0; k < N_SPEC; k++) fl[k] = ($urandom % 100) < 3;
         step("", wr, CTL_W'($urandom), cv, fl, er, ack);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule